// File: doc/BRIEF.md
# Strap-or-Serial Control Register Slave

This block lets a single bus master (usually a microcontroller) read and write a small bank of 8-bit control registers over an I2C-compatible two-wire link. It also decides where the chip's four control levels (amplitude, rate, gain, threshold) come from. A mode input makes that choice. When the mode input is low, each control output copies a strap input that is tied high or low on the board. When it is high, the control outputs take bit 0 of the matching register and the straps are ignored.

SCL and SDA are sampled on the system clock through two-flop synchronisers. START and STOP are found from SDA edges while SCL is high. The slave only ever pulls SDA low, through an output enable, and it never drives SCL. Every transfer has the same shape: the device address, then a register pointer, then either one data byte, or a repeated START followed by one byte read back. While the mode input is low the serial port stays idle and never acknowledges.

Top module: `strap_i2c_ctl`

## Requirements
- R1: A synchronous active-high reset clears all four control registers to 0x00 and releases SDA (sda_oe_o low). In serial mode the control outputs then read 0.
- R2: With mode_i low, ctl_ampl_o, ctl_rate_o, ctl_gain_o and ctl_thr_o equal strap_ampl_i, strap_rate_i, strap_gain_i and strap_thr_i, combinationally.
- R3: With mode_i low, the serial port is inert. sda_oe_o stays low, no byte is acknowledged and no register changes.
- R4: With mode_i high, the control outputs are bit 0 of the registers at pointers 0x00 (amplitude), 0x01 (rate), 0x02 (gain) and 0x03 (threshold). Strap inputs have no effect in this mode.
- R5: The device answers to the 7-bit address 0001100 (byte 0x18 to write, 0x19 to read). Any other address gets no ACK, and the slave stays silent until the next START.
- R6: A write is START, 0x18, pointer, data, STOP. The slave ACKs each of these three bytes by holding SDA low during the ninth clock. A second data byte in the same transfer is not acknowledged and is not written.
- R7: A read is a pointer write followed by a repeated START and 0x19. The slave then returns the addressed byte MSB first, and sda_oe_o changes only while SCL is low.
- R8: Pointer 0x04 is a read-only status byte. Bits 3:0 hold the current {threshold, gain, rate, amplitude} outputs and bits 7:4 read 0. Writes to it are ignored.
- R9: Pointers 0x05 to 0xFF hold nothing. Writes to them are acknowledged but ignored, and reads return 0x00.
- R10: A START or STOP in the middle of a byte aborts the transfer. A register changes only after all eight bits of its data byte have been received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 1 | 0: straps drive controls, 1: registers drive controls |
| strap_ampl_i | input | 1 | Amplitude strap level |
| strap_rate_i | input | 1 | Rate strap level |
| strap_gain_i | input | 1 | Gain strap level |
| strap_thr_i | input | 1 | Threshold strap level |
| scl_i | input | 1 | Serial clock from the master |
| sda_i | input | 1 | Resolved serial data line |
| sda_oe_o | output | 1 | Pull SDA low when high |
| ctl_ampl_o | output | 1 | Amplitude control output |
| ctl_rate_o | output | 1 | Rate control output |
| ctl_gain_o | output | 1 | Gain control output |
| ctl_thr_o | output | 1 | Threshold control output |

## Verification
A bus edge passes through two synchroniser flops and one edge register, so the slave reacts three to four system clocks after SCL moves. It changes SDA about that long after a falling SCL edge. The bench holds each SCL phase for ten clocks and samples SDA at the end of the high phase, well after the slave's response has settled. A register update lands one clock after the SCL fall that closes its data byte, which is long before STOP, so control outputs and read-backs are checked after the transfer ends. The strap path has no register in it, so control outputs are compared at the falling edge after a strap or mode change.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

    localparam int          BYTE_W     = 8;
    localparam int          NUM_CTL    = 4;
    localparam int          PTR_W      = $clog2(NUM_CTL);
    localparam logic [6:0]  DEV_ADDR   = 7'b0001100;
    localparam logic [7:0]  STATUS_PTR = 8'h04;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RECV,
        ST_ACK,
        ST_SEND,
        ST_HOLD
    } fsm_e;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_PTR,
        PH_DATA
    } phase_e;

    typedef struct packed {
        logic thr;
        logic gain;
        logic rate;
        logic ampl;
    } ctl_t;

    typedef struct packed {
        logic              en;
        logic [BYTE_W-1:0] ptr;
        logic [BYTE_W-1:0] data;
    } wr_req_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_ev_t;

    function automatic logic addr_hit(input logic [BYTE_W-1:0] b);
        return b[BYTE_W-1:1] == DEV_ADDR;
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import ctl_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);

    logic [STAGES-1:0] scl_sh, sda_sh;
    logic              scl_q, sda_q;
    logic              scl_s, sda_s;

    assign scl_s = scl_sh[STAGES-1];
    assign sda_s = sda_sh[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[STAGES-2:0], sda_i};
            scl_q  <= scl_s;
            sda_q  <= sda_s;
        end
    end

    always_comb begin
        ev.scl_rise = scl_s & ~scl_q;
        ev.scl_fall = ~scl_s & scl_q;
        ev.start    = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop     = scl_s & scl_q & ~sda_q & sda_s;
        ev.sda      = sda_s;
    end

endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
    import ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  bus_ev_t           ev,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] ptr,
    output wr_req_t           wr,
    output logic              sda_oe,
    output logic              busy
);

    fsm_e              state;
    phase_e            phase;
    logic [3:0]        cnt;
    logic [BYTE_W-1:0] sh;
    logic              rw;

    assign busy = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            phase  <= PH_ADDR;
            cnt    <= '0;
            sh     <= '0;
            ptr    <= '0;
            rw     <= 1'b0;
            sda_oe <= 1'b0;
            wr     <= '0;
        end else begin
            wr.en <= 1'b0;
            if (!enable) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else if (ev.start) begin
                state  <= ST_RECV;
                phase  <= PH_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (ev.stop) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_RECV: begin
                        if (ev.scl_rise) begin
                            sh  <= {sh[BYTE_W-2:0], ev.sda};
                            cnt <= cnt + 4'd1;
                        end else if (ev.scl_fall && cnt == 4'd8) begin
                            cnt <= '0;
                            case (phase)
                                PH_ADDR: begin
                                    if (addr_hit(sh)) begin
                                        rw     <= sh[0];
                                        state  <= ST_ACK;
                                        sda_oe <= 1'b1;
                                    end else begin
                                        state <= ST_IDLE;
                                    end
                                end
                                PH_PTR: begin
                                    ptr    <= sh;
                                    state  <= ST_ACK;
                                    sda_oe <= 1'b1;
                                end
                                default: begin
                                    wr     <= '{en: 1'b1, ptr: ptr, data: sh};
                                    state  <= ST_ACK;
                                    sda_oe <= 1'b1;
                                end
                            endcase
                        end
                    end
                    ST_ACK: begin
                        if (ev.scl_fall) begin
                            case (phase)
                                PH_ADDR: begin
                                    if (rw) begin
                                        state  <= ST_SEND;
                                        sh     <= rd_data;
                                        sda_oe <= ~rd_data[BYTE_W-1];
                                        cnt    <= 4'd1;
                                    end else begin
                                        state  <= ST_RECV;
                                        phase  <= PH_PTR;
                                        sda_oe <= 1'b0;
                                    end
                                end
                                PH_PTR: begin
                                    state  <= ST_RECV;
                                    phase  <= PH_DATA;
                                    sda_oe <= 1'b0;
                                end
                                default: begin
                                    state  <= ST_HOLD;
                                    sda_oe <= 1'b0;
                                end
                            endcase
                        end
                    end
                    ST_SEND: begin
                        if (ev.scl_fall) begin
                            if (cnt == 4'd8) begin
                                state  <= ST_HOLD;
                                sda_oe <= 1'b0;
                            end else begin
                                sh     <= {sh[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~sh[BYTE_W-2];
                                cnt    <= cnt + 4'd1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/ctl_regfile.sv
module ctl_regfile
    import ctl_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      mode,
    input  wr_req_t                   wr,
    input  logic [BYTE_W-1:0]         rd_ptr,
    input  ctl_t                      straps,
    output logic [BYTE_W-1:0]         rd_data,
    output ctl_t                      ctl,
    output logic [NUM_CTL*BYTE_W-1:0] regs_flat
);

    logic [BYTE_W-1:0] regs_q [NUM_CTL];
    ctl_t              ctl_reg;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_CTL; i++) regs_q[i] <= '0;
        end else if (wr.en) begin
            for (int i = 0; i < NUM_CTL; i++)
                if (wr.ptr == 8'(i)) regs_q[i] <= wr.data;
        end
    end

    generate
        for (genvar g = 0; g < NUM_CTL; g++) begin : g_flat
            assign regs_flat[g*BYTE_W +: BYTE_W] = regs_q[g];
        end
    endgenerate

    assign ctl_reg = '{thr: regs_q[3][0], gain: regs_q[2][0],
                       rate: regs_q[1][0], ampl: regs_q[0][0]};
    assign ctl     = mode ? ctl_reg : straps;

    always_comb begin
        if (rd_ptr < 8'(NUM_CTL))
            rd_data = regs_q[rd_ptr[PTR_W-1:0]];
        else if (rd_ptr == STATUS_PTR)
            rd_data = {4'b0, ctl};
        else
            rd_data = '0;
    end

endmodule

// File: rtl/strap_i2c_ctl.sv
module strap_i2c_ctl
    import ctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic mode_i,
    input  logic strap_ampl_i,
    input  logic strap_rate_i,
    input  logic strap_gain_i,
    input  logic strap_thr_i,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe_o,
    output logic ctl_ampl_o,
    output logic ctl_rate_o,
    output logic ctl_gain_o,
    output logic ctl_thr_o
);

    bus_ev_t                   ev;
    wr_req_t                   wr;
    logic                      wr_en;
    logic [BYTE_W-1:0]         ptr;
    logic [BYTE_W-1:0]         rd_data;
    logic                      busy;
    ctl_t                      straps;
    ctl_t                      ctl;
    logic [NUM_CTL*BYTE_W-1:0] regs_flat;

    assign straps = '{thr: strap_thr_i, gain: strap_gain_i,
                      rate: strap_rate_i, ampl: strap_ampl_i};
    assign wr_en  = wr.en;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2c_slave_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .enable  (mode_i),
        .ev      (ev),
        .rd_data (rd_data),
        .ptr     (ptr),
        .wr      (wr),
        .sda_oe  (sda_oe_o),
        .busy    (busy)
    );

    ctl_regfile u_regs (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode_i),
        .wr        (wr),
        .rd_ptr    (ptr),
        .straps    (straps),
        .rd_data   (rd_data),
        .ctl       (ctl),
        .regs_flat (regs_flat)
    );

    assign ctl_ampl_o = ctl.ampl;
    assign ctl_rate_o = ctl.rate;
    assign ctl_gain_o = ctl.gain;
    assign ctl_thr_o  = ctl.thr;

endmodule

// File: rtl/strap_i2c_ctl_chk.sv
module strap_i2c_ctl_chk (
    input logic        clk,
    input logic        rst,
    input logic        mode_i,
    input logic        scl_i,
    input logic        sda_oe_o,
    input logic        wr_en,
    input logic        busy,
    input logic [31:0] regs_flat
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (regs_flat == '0 && !sda_oe_o)); // R1

    AST_STRAP_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        !mode_i |=> !sda_oe_o); // R3

    AST_STRAP_REGS_HELD: assert property (@(posedge clk) disable iff (rst)
        (!mode_i && !$past(mode_i) && !$past(rst)) |=> $stable(regs_flat)); // R3

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sda_oe_o); // R5

    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        (mode_i && $past(mode_i) && !$past(rst) && sda_oe_o != $past(sda_oe_o))
        |-> !scl_i); // R7

    AST_REG_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && regs_flat != $past(regs_flat)) |-> $past(wr_en)); // R10

endmodule

bind strap_i2c_ctl strap_i2c_ctl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode_i    (mode_i),
    .scl_i     (scl_i),
    .sda_oe_o  (sda_oe_o),
    .wr_en     (wr_en),
    .busy      (busy),
    .regs_flat (regs_flat)
);

// File: tb/test_strap_i2c_ctl.sv
module test_strap_i2c_ctl;

    localparam int H = 10;

    // {ptr, data, expected readback, expected {thr,gain,rate,ampl}}
    localparam logic [27:0] VEC [6] = '{
        28'h0001011, 28'h01FEFE1, 28'h0281815,
        28'h035B5BD, 28'h07AA00D, 28'h04FF0DD
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode = 1'b1;
    logic [3:0] straps = 4'b0000;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_line;
    logic sda_oe;
    logic c_ampl, c_rate, c_gain, c_thr;
    logic [3:0] ctl;
    int n_vec = 0, n_bad = 0;
    int oe_cnt = 0;

    always #2 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;
    assign ctl = {c_thr, c_gain, c_rate, c_ampl};

    always @(posedge clk) if (sda_oe) oe_cnt <= oe_cnt + 1;

    strap_i2c_ctl i_strap_i2c_ctl (
        .clk          (clk),
        .rst          (rst),
        .mode_i       (mode),
        .strap_ampl_i (straps[0]),
        .strap_rate_i (straps[1]),
        .strap_gain_i (straps[2]),
        .strap_thr_i  (straps[3]),
        .scl_i        (scl_m),
        .sda_i        (sda_line),
        .sda_oe_o     (sda_oe),
        .ctl_ampl_o   (c_ampl),
        .ctl_rate_o   (c_rate),
        .ctl_gain_o   (c_gain),
        .ctl_thr_o    (c_thr)
    );

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; w(H); scl_m = 1'b1; w(H);
        sda_m = 1'b0; w(H); scl_m = 1'b0; w(H);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; w(H); scl_m = 1'b1; w(H); sda_m = 1'b1; w(H);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; w(H); scl_m = 1'b1; w(H); scl_m = 1'b0; w(H);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; w(H); scl_m = 1'b1; w(H); b = sda_line; scl_m = 1'b0; w(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        get_bit(a);
        ack = ~a;
    endtask

    task automatic read_byte(output logic [7:0] v);
        for (int i = 7; i >= 0; i--) get_bit(v[i]);
        put_bit(1'b1);
    endtask

    task automatic reg_write(input logic [7:0] p, input logic [7:0] d, output logic [2:0] acks);
        i2c_start();
        send_byte(8'h18, acks[2]);
        send_byte(p, acks[1]);
        send_byte(d, acks[0]);
        i2c_stop();
    endtask

    task automatic reg_read(input logic [7:0] p, output logic [7:0] v, output logic [2:0] acks);
        i2c_start();
        send_byte(8'h18, acks[2]);
        send_byte(p, acks[1]);
        i2c_start();
        send_byte(8'h19, acks[0]);
        read_byte(v);
        i2c_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [2:0] acks;
        logic [7:0] v;
        logic a;
        int oe0;

        // R1: reset state
        w(5); rst = 1'b0; w(2);
        check("R1 ctl", ctl, 4'h0);
        check("R1 oe", sda_oe, 1'b0);
        reg_read(8'h03, v, acks);
        check("R1 read", v, 8'h00);

        // table walk: R4 outputs, R6 acks, R7/R8/R9 readback
        for (int k = 0; k < 6; k++) begin
            logic [7:0] p, d, er;
            logic [3:0] ec;
            string rq;
            {p, d, er, ec} = VEC[k];
            rq = (p == 8'h04) ? "R8" : (p > 8'h04) ? "R9" : "R7";
            reg_write(p, d, acks);
            check("R6 acks", acks, 3'b111);
            check("R4 ctl", ctl, ec);
            reg_read(p, v, acks);
            check(rq, v, er);
            check("R7 acks", acks, 3'b111);
        end

        // R4: straps ignored in serial mode
        straps = 4'b0010; w(2);
        check("R4 strap ignored", ctl, 4'hD);

        // R6: second data byte not acked nor written
        i2c_start();
        send_byte(8'h18, a); send_byte(8'h00, a); send_byte(8'h00, a);
        check("R6 first data ack", a, 1'b1);
        send_byte(8'hFF, a);
        check("R6 extra byte nack", a, 1'b0);
        i2c_stop();
        reg_read(8'h00, v, acks);
        check("R6 extra byte dropped", v, 8'h00);
        check("R6 ctl", ctl, 4'hC);

        // R5: foreign address
        i2c_start();
        send_byte(8'h1A, a);
        check("R5 foreign nack", a, 1'b0);
        send_byte(8'h00, a);
        check("R5 silent ptr", a, 1'b0);
        send_byte(8'h01, a);
        i2c_stop();
        reg_read(8'h00, v, acks);
        check("R5 reg kept", v, 8'h00);

        // R10: STOP aborts data byte
        i2c_start();
        send_byte(8'h18, a); send_byte(8'h02, a);
        for (int i = 0; i < 4; i++) put_bit(1'b0);
        i2c_stop();
        reg_read(8'h02, v, acks);
        check("R10 stop abort", v, 8'h81);

        // R10: repeated START aborts data byte, then read
        i2c_start();
        send_byte(8'h18, a); send_byte(8'h03, a);
        for (int i = 0; i < 5; i++) put_bit(1'b0);
        i2c_start();
        send_byte(8'h19, a);
        read_byte(v);
        i2c_stop();
        check("R10 start abort", v, 8'h5B);

        // R2: strap mode follows straps
        mode = 1'b0;
        straps = 4'b1010; w(2);
        check("R2 straps a", ctl, 4'hA);
        straps = 4'b0101; w(2);
        check("R2 straps b", ctl, 4'h5);

        // R3: port inert in strap mode
        oe0 = oe_cnt;
        reg_write(8'h03, 8'h00, acks);
        check("R3 no ack", acks, 3'b000);
        check("R3 oe never", oe_cnt - oe0, 0);
        mode = 1'b1; w(2);
        check("R3 regs kept", ctl, 4'hC);
        reg_read(8'h03, v, acks);
        check("R3 readback", v, 8'h5B);

        // R1: reset mid-run
        rst = 1'b1; w(3); rst = 1'b0; w(2);
        check("R1 ctl after reset", ctl, 4'h0);
        reg_read(8'h02, v, acks);
        check("R1 reg after reset", v, 8'h00);

        summary();
        $finish;
    end

endmodule